// File: doc/BRIEF.md
# Write-Port Burst and Abort Sequencer

This block sits between a word producer and one write port of a shared memory controller. Words that the producer offers go straight into the controller's write FIFO. Once a full burst of words has been accepted, the block raises a burst request carrying the destination address. It latched that address together with the first word of the burst, and it holds the request until the controller acknowledges it. The block also keeps a count of the words that sit in the controller FIFO. It adds one for each word written and subtracts one for each word the controller reports as drained. Its ready output drops when the FIFO would overflow.

The controller port has no working flush input, so the block discards a partly built burst another way. When the producer asks to abandon that burst, the block closes its input and requests a full-length burst to a reserved scratch address, which carries the stale words away. It then waits for the controller to report an empty FIFO. After that it keeps the input closed for a fixed guard interval, so that no new word can slip into the tail of the discarded transfer, and only then reopens.

Top module: `wbs_burst_seq`

## Requirements
- R1: After reset `in_ready` is 1, `mc_req` is 0 and `wf_wr_en` is 0.
- R2: `wf_wr_en` is 1 in exactly the cycles where `in_valid` and `in_ready` are both 1, and `wf_data` equals `in_data` in that same cycle.
- R3: After `BURST_LEN` (64) accepted words, `mc_req` is 1 from the following cycle. `mc_addr` then equals `in_addr` as sampled with the first word of the burst, and `in_ready` is 0 while the request is pending.
- R4: A raised `mc_req` keeps its value, and `mc_addr` stays stable, until a cycle with `mc_ack` = 1. In the cycle after that acknowledge `mc_req` is 0.
- R5: An `abort_req` pulse while a burst is partly filled (1 to 64 words, including a word accepted in the same cycle) makes the block request a burst to `SCRATCH_ADDR` from the next cycle. No word is accepted from then until the guard interval ends.
- R6: After the scratch burst is acknowledged, `in_ready` stays 0 for as long as `wf_empty` is 0.
- R7: After the first cycle in which `wf_empty` is seen as 1, `in_ready` stays 0 for exactly `GUARD_CYCLES` (32) further cycles and then returns to 1.
- R8: `abort_req` has no effect while no burst is being filled: no request is raised and `in_ready` stays 1.
- R9: `abort_req` has no effect while a normal burst request is pending: `mc_addr` keeps the destination address.
- R10: When the queued-word count (words written minus pulses on `wf_pop`) reaches `FIFO_WORDS` (256 = 1024 bytes / 4-byte words), `in_ready` is 0 and `wf_wr_en` stays 0. `in_ready` returns to 1 in the cycle after one `wf_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a word |
| in_data | input | DATA_W | Offered word |
| in_addr | input | ADDR_W | Burst destination, sampled with the first word of a burst |
| in_ready | output | 1 | Block accepts the offered word this cycle |
| abort_req | input | 1 | Abandon the burst being filled |
| wf_wr_en | output | 1 | Write strobe into the controller write FIFO |
| wf_data | output | DATA_W | Word written into the controller write FIFO |
| wf_pop | input | 1 | Controller drained one word from its FIFO |
| wf_empty | input | 1 | Controller write FIFO is empty |
| mc_req | output | 1 | Burst request to the controller |
| mc_addr | output | ADDR_W | Burst address, valid while `mc_req` is 1 |
| mc_ack | input | 1 | Controller accepts the pending request |

## Verification
The write strobe and data are combinational, so the bench checks them a short delay after it drives the inputs, before the accepting edge. The request, its address and the closed input follow from a registered state. The bench therefore checks them at the falling edge after the edge that accepted the last word, the abort or the acknowledge. For the guard interval, the bench counts the falling edges with `in_ready` low that follow the first edge on which the empty flag is high, and it expects exactly 32. A sweep aborts after every fill level from 1 to 63 words, plus one case where the abort coincides with the 64th word, and so covers every point at which a burst can be abandoned.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_FILL       = 3'd1,
      ST_REQ        = 3'd2,
      ST_ABORT_REQ  = 3'd3,
      ST_WAIT_EMPTY = 3'd4,
      ST_GUARD      = 3'd5
   } seq_state_e;

endpackage

// File: rtl/wbs_level_ctr.sv
module wbs_level_ctr #(
   parameter int CAP   = 256,
   parameter int LVL_W = $clog2(CAP + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             dec,
   output logic [LVL_W-1:0] level,
   output logic             room
);

   logic [LVL_W-1:0] level_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level_q <= '0;
      end else begin
         case ({inc, dec})
            2'b10:   level_q <= level_q + LVL_W'(1);
            2'b01:   level_q <= level_q - LVL_W'(1);
            default: level_q <= level_q;
         endcase
      end
   end

   assign level = level_q;
   assign room  = (level_q < LVL_W'(CAP));

endmodule

// File: rtl/wbs_guard_timer.sv
module wbs_guard_timer #(
   parameter int GUARD_CYCLES = 32,
   parameter int CNT_W        = $clog2(GUARD_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic last
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= CNT_W'(GUARD_CYCLES);
      end else if (run && cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign last = run && (cnt_q == CNT_W'(1));

endmodule

// File: rtl/wbs_fsm.sv
module wbs_fsm
   import wbs_pkg::*;
#(
   parameter int                BURST_LEN    = 64,
   parameter int                ADDR_W       = 32,
   parameter logic [ADDR_W-1:0] SCRATCH_ADDR = '1,
   parameter int                FILL_W       = $clog2(BURST_LEN + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] dest_addr,
   input  logic              abort_req,
   input  logic              mc_ack,
   input  logic              wf_empty,
   input  logic              guard_last,
   output seq_state_e        state,
   output logic              open_in,
   output logic              guard_load,
   output logic              guard_run,
   output logic              mc_req,
   output logic [ADDR_W-1:0] mc_addr
);

   seq_state_e        st_q, st_d;
   logic [FILL_W-1:0] fill_q, fill_d;
   logic [ADDR_W-1:0] addr_q, addr_d;

   always_comb begin
      st_d       = st_q;
      fill_d     = fill_q;
      addr_d     = addr_q;
      guard_load = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (push) begin
               addr_d = dest_addr;
               fill_d = FILL_W'(1);
               st_d   = ST_FILL;
            end
         end
         ST_FILL: begin
            if (abort_req) begin
               fill_d = '0;
               st_d   = ST_ABORT_REQ;
            end else if (push) begin
               fill_d = fill_q + FILL_W'(1);
               if (fill_q == FILL_W'(BURST_LEN - 1)) begin
                  st_d = ST_REQ;
               end
            end
         end
         ST_REQ: begin
            if (mc_ack) begin
               fill_d = '0;
               st_d   = ST_IDLE;
            end
         end
         ST_ABORT_REQ: begin
            if (mc_ack) begin
               st_d = ST_WAIT_EMPTY;
            end
         end
         ST_WAIT_EMPTY: begin
            if (wf_empty) begin
               guard_load = 1'b1;
               st_d       = ST_GUARD;
            end
         end
         ST_GUARD: begin
            if (guard_last) begin
               st_d = ST_IDLE;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fill_q <= '0;
         addr_q <= '0;
      end else begin
         st_q   <= st_d;
         fill_q <= fill_d;
         addr_q <= addr_d;
      end
   end

   assign state     = st_q;
   assign open_in   = (st_q == ST_IDLE) || (st_q == ST_FILL);
   assign guard_run = (st_q == ST_GUARD);
   assign mc_req    = (st_q == ST_REQ) || (st_q == ST_ABORT_REQ);
   assign mc_addr   = (st_q == ST_ABORT_REQ) ? SCRATCH_ADDR : addr_q;

endmodule

// File: rtl/wbs_burst_seq.sv
module wbs_burst_seq
   import wbs_pkg::*;
#(
   parameter int                DATA_W       = 32,
   parameter int                ADDR_W       = 32,
   parameter int                BURST_LEN    = 64,
   parameter int                FIFO_BYTES   = 1024,
   parameter int                GUARD_CYCLES = 32,
   parameter logic [ADDR_W-1:0] SCRATCH_ADDR = ADDR_W'('hFFFF_0000)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              in_ready,
   input  logic              abort_req,
   output logic              wf_wr_en,
   output logic [DATA_W-1:0] wf_data,
   input  logic              wf_pop,
   input  logic              wf_empty,
   output logic              mc_req,
   output logic [ADDR_W-1:0] mc_addr,
   input  logic              mc_ack
);

   localparam int WORD_BYTES = DATA_W / 8;
   localparam int FIFO_WORDS = FIFO_BYTES / WORD_BYTES;
   localparam int LVL_W      = $clog2(FIFO_WORDS + 1);
   localparam int FILL_W     = $clog2(BURST_LEN + 1);
   localparam int GUARD_W    = $clog2(GUARD_CYCLES + 1);

   generate
      if (DATA_W % 8 != 0) begin : g_bad_width
         $error("DATA_W must be a whole number of bytes");
      end
      if (BURST_LEN < 2) begin : g_bad_burst
         $error("BURST_LEN must be at least 2");
      end
      if (FIFO_WORDS < BURST_LEN) begin : g_bad_fifo
         $error("FIFO must hold at least one burst");
      end
      if (GUARD_CYCLES < 1) begin : g_bad_guard
         $error("GUARD_CYCLES must be at least 1");
      end
   endgenerate

   seq_state_e       state;
   logic             open_in;
   logic             room;
   logic [LVL_W-1:0] level;
   logic             guard_load;
   logic             guard_run;
   logic             guard_last;
   logic             push;

   assign in_ready = open_in && room;
   assign push     = in_valid && in_ready;
   assign wf_wr_en = push;
   assign wf_data  = in_data;

   wbs_level_ctr #(
      .CAP   (FIFO_WORDS),
      .LVL_W (LVL_W)
   ) u_level (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (push),
      .dec   (wf_pop),
      .level (level),
      .room  (room)
   );

   wbs_guard_timer #(
      .GUARD_CYCLES (GUARD_CYCLES),
      .CNT_W        (GUARD_W)
   ) u_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (guard_load),
      .run   (guard_run),
      .last  (guard_last)
   );

   wbs_fsm #(
      .BURST_LEN    (BURST_LEN),
      .ADDR_W       (ADDR_W),
      .SCRATCH_ADDR (SCRATCH_ADDR),
      .FILL_W       (FILL_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (push),
      .dest_addr  (in_addr),
      .abort_req  (abort_req),
      .mc_ack     (mc_ack),
      .wf_empty   (wf_empty),
      .guard_last (guard_last),
      .state      (state),
      .open_in    (open_in),
      .guard_load (guard_load),
      .guard_run  (guard_run),
      .mc_req     (mc_req),
      .mc_addr    (mc_addr)
   );

endmodule

// File: rtl/wbs_burst_seq_chk.sv
module wbs_burst_seq_chk
   import wbs_pkg::*;
#(
   parameter int                ADDR_W       = 32,
   parameter int                FIFO_WORDS   = 256,
   parameter int                LVL_W        = 9,
   parameter logic [ADDR_W-1:0] SCRATCH_ADDR = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              abort_req,
   input logic              wf_wr_en,
   input logic              wf_empty,
   input logic              mc_req,
   input logic [ADDR_W-1:0] mc_addr,
   input logic              mc_ack,
   input seq_state_e        state,
   input logic [LVL_W-1:0]  level
);

   // R4: a pending request and its address stay put until acknowledged
   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_req && !mc_ack) |=> (mc_req && $stable(mc_addr)));

   // R4: the request drops right after the acknowledge
   assert_req_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mc_req && mc_ack) |=> !mc_req);

   // R5: abort while filling leads to a scratch burst
   assert_abort_dummy_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL && abort_req) |=> (mc_req && mc_addr == SCRATCH_ADDR));

   // R6: no words are written while the discard sequence runs
   assert_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ABORT_REQ || state == ST_WAIT_EMPTY || state == ST_GUARD) |-> !wf_wr_en);

   // R6: the empty wait holds until the flag rises
   assert_wait_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_EMPTY && !wf_empty) |=> (state == ST_WAIT_EMPTY));

   // R7: input stays closed through the guard interval
   assert_guard_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_GUARD) |-> !in_ready);

   // R8: an abort with no burst being filled raises no request
   assert_idle_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && abort_req) |=> !mc_req);

   // R10: queued count never exceeds the FIFO capacity
   assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(FIFO_WORDS));

   // R10: a full FIFO closes the input
   assert_full_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (level == LVL_W'(FIFO_WORDS)) |-> !in_ready);

endmodule

bind wbs_burst_seq wbs_burst_seq_chk #(
   .ADDR_W       (ADDR_W),
   .FIFO_WORDS   (FIFO_WORDS),
   .LVL_W        (LVL_W),
   .SCRATCH_ADDR (SCRATCH_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_ready  (in_ready),
   .abort_req (abort_req),
   .wf_wr_en  (wf_wr_en),
   .wf_empty  (wf_empty),
   .mc_req    (mc_req),
   .mc_addr   (mc_addr),
   .mc_ack    (mc_ack),
   .state     (state),
   .level     (level)
);

// File: tb/tb_wbs_burst_seq.sv
`timescale 1ns/1ps
module tb_wbs_burst_seq;

   localparam int          BURST    = 64;
   localparam int          CAPW     = 256;
   localparam int          GUARD    = 32;
   localparam logic [31:0] SCRATCH  = 32'hFFFF_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_data = '0;
   logic [31:0] in_addr = '0;
   logic        in_ready;
   logic        abort_req = 1'b0;
   logic        wf_wr_en;
   logic [31:0] wf_data;
   logic        wf_pop = 1'b0;
   logic        wf_empty;
   logic        mc_req;
   logic [31:0] mc_addr;
   logic        mc_ack = 1'b0;

   int n_chk = 0;
   int n_fail = 0;
   int bl = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   assign wf_empty = (bl == 0);

   always @(posedge clk) begin
      if (!rst_n) bl <= 0;
      else bl <= bl + (wf_wr_en ? 1 : 0) - (wf_pop ? 1 : 0);
   end

   wbs_burst_seq dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .in_addr   (in_addr),
      .in_ready  (in_ready),
      .abort_req (abort_req),
      .wf_wr_en  (wf_wr_en),
      .wf_data   (wf_data),
      .wf_pop    (wf_pop),
      .wf_empty  (wf_empty),
      .mc_req    (mc_req),
      .mc_addr   (mc_addr),
      .mc_ack    (mc_ack)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // push n words; first word carries addr, later words a different address
   task automatic push_words(input int n, input logic [31:0] addr, input bit do_chk);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = addr + 32'(i) * 32'h11;
         in_addr  = (i == 0) ? addr : ~addr;
         #1;
         if (do_chk) begin
            chk(wf_wr_en == 1'b1, "R2 strobe", 32'(wf_wr_en), 32'h1);
            chk(wf_data == in_data, "R2 data", wf_data, in_data);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      #1;
   endtask

   task automatic ack_once();
      mc_ack = 1'b1;
      @(negedge clk);
      mc_ack = 1'b0;
      #1;
   endtask

   task automatic pop_words(input int n);
      for (int i = 0; i < n; i++) begin
         wf_pop = 1'b1;
         @(negedge clk);
      end
      wf_pop = 1'b0;
      #1;
   endtask

   // full discard flow after an abort request edge; k words were in the burst
   task automatic discard_flow(input int k);
      int lows;
      chk(mc_req == 1'b1, "R5 dummy req", 32'(mc_req), 32'h1);
      chk(mc_addr == SCRATCH, "R5 scratch addr", mc_addr, SCRATCH);
      in_valid = 1'b1;
      #1;
      chk(wf_wr_en == 1'b0, "R5 no write", 32'(wf_wr_en), 32'h0);
      in_valid = 1'b0;
      ack_once();
      chk(mc_req == 1'b0, "R4 drop after ack", 32'(mc_req), 32'h0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         chk(in_ready == 1'b0, "R6 wait empty", 32'(in_ready), 32'h0);
      end
      pop_words(k);
      chk(in_ready == 1'b0, "R6 before empty seen", 32'(in_ready), 32'h0);
      lows = 0;
      for (int i = 0; i < GUARD + 8; i++) begin
         @(negedge clk);
         #1;
         if (in_ready) break;
         lows++;
      end
      chk(lows == GUARD, "R7 guard length", 32'(lows), 32'(GUARD));
   endtask

   initial begin
      while (cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      chk(in_ready == 1'b1, "R1 ready", 32'(in_ready), 32'h1);
      chk(mc_req == 1'b0, "R1 req", 32'(mc_req), 32'h0);
      chk(wf_wr_en == 1'b0, "R1 wr_en", 32'(wf_wr_en), 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // R3/R4: first normal burst
      push_words(BURST, 32'h0000_1000, 1'b1);
      chk(mc_req == 1'b1, "R3 req", 32'(mc_req), 32'h1);
      chk(mc_addr == 32'h0000_1000, "R3 addr", mc_addr, 32'h0000_1000);
      chk(in_ready == 1'b0, "R3 closed", 32'(in_ready), 32'h0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         chk(mc_req == 1'b1 && mc_addr == 32'h0000_1000, "R4 hold", mc_addr, 32'h0000_1000);
      end
      ack_once();
      chk(mc_req == 1'b0, "R4 drop", 32'(mc_req), 32'h0);
      chk(in_ready == 1'b1, "R4 reopen", 32'(in_ready), 32'h1);

      // R9: abort during pending request is ignored
      push_words(BURST, 32'h0000_2000, 1'b0);
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      #1;
      chk(mc_req == 1'b1, "R9 req kept", 32'(mc_req), 32'h1);
      chk(mc_addr == 32'h0000_2000, "R9 addr kept", mc_addr, 32'h0000_2000);
      ack_once();

      // R8: abort with no burst filling
      abort_req = 1'b1;
      @(negedge clk);
      abort_req = 1'b0;
      #1;
      chk(mc_req == 1'b0, "R8 no req", 32'(mc_req), 32'h0);
      chk(in_ready == 1'b1, "R8 ready", 32'(in_ready), 32'h1);
      @(negedge clk);
      #1;
      chk(mc_req == 1'b0, "R8 no req later", 32'(mc_req), 32'h0);

      // R10: fill the FIFO to capacity with two more bursts and no drain
      push_words(BURST, 32'h0000_3000, 1'b0);
      ack_once();
      push_words(BURST, 32'h0000_4000, 1'b0);
      ack_once();
      chk(bl == CAPW, "R10 model level", 32'(bl), 32'(CAPW));
      chk(in_ready == 1'b0, "R10 full closed", 32'(in_ready), 32'h0);
      in_valid = 1'b1;
      #1;
      chk(wf_wr_en == 1'b0, "R10 no write", 32'(wf_wr_en), 32'h0);
      in_valid = 1'b0;
      pop_words(1);
      chk(in_ready == 1'b1, "R10 reopen", 32'(in_ready), 32'h1);
      pop_words(CAPW - 1);

      // R5/R6/R7: abort after every partial fill level
      for (int k = 1; k < BURST; k++) begin
         push_words(k, 32'h0001_0000 + 32'(k), 1'b0);
         abort_req = 1'b1;
         @(negedge clk);
         abort_req = 1'b0;
         #1;
         discard_flow(k);
      end

      // R5: abort together with the final word of a burst
      push_words(BURST - 1, 32'h0002_0000, 1'b0);
      in_valid  = 1'b1;
      in_data   = 32'hDEAD_BEEF;
      abort_req = 1'b1;
      @(negedge clk);
      in_valid  = 1'b0;
      abort_req = 1'b0;
      #1;
      discard_flow(BURST);

      // after the discard a normal burst works again (R3)
      push_words(BURST, 32'h0000_5000, 1'b0);
      chk(mc_req == 1'b1 && mc_addr == 32'h0000_5000, "R3 after discard", mc_addr, 32'h0000_5000);
      ack_once();
      pop_words(BURST);

      finish_run();
   end

endmodule